// File: doc/BRIEF.md
# Multi-Mode Address Generation Unit

This unit computes the effective memory address of one operand per cycle. Each request carries an addressing-mode code, a base register value, an index register value, a 16-bit instruction constant, a 2-bit scale code, a 2-bit access-size code, and the start and length of a circular buffer. The result is registered and appears one cycle later.

The general modes cover register indirect, base plus displacement, base plus index, absolute, and scaled index. Post-increment and pre-decrement modes also return a new base value for the register file to write back. Two signal-processing modes step a pointer through a buffer. The circular mode wraps at the buffer edges. The bit-reversed mode walks through a power-of-two buffer in the order that a radix-2 FFT reorder needs.

Registers, instruction decode and any second memory read are the caller's job. The unit only computes the address and reports whether the base must be updated, and with what value.

Top module: `addr_gen_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_vld`, `upd_en`, `ea` and `upd_val` are all zero.
- R2: A request accepted with `in_vld` high gives `out_vld` high exactly one clock later. A cycle with `in_vld` low gives `out_vld` low one clock later.
- R3: Mode code 0 (register indirect) gives `ea` = `base`. Mode code 3 (absolute) gives `ea` = `disp` zero-extended to the address width. Codes 10 to 15 behave like code 0.
- R4: Mode code 1 (displacement) gives `ea` = `base` + `disp`, with `disp` sign-extended from bit 15.
- R5: Mode code 2 (indexed) gives `ea` = `base` + `index`.
- R6: Mode code 4 (scaled) gives `ea` = `base` + sign-extended `disp` + (`index` << `scale`). Scale codes 0, 1, 2 and 3 mean a factor of 1, 2, 4 and 8.
- R7: Mode code 5 (post-increment) gives `ea` = `base` and `upd_val` = `base` + 2^`size`. Size codes 0 to 3 mean 1, 2, 4 and 8 bytes.
- R8: Mode code 6 (pre-decrement) gives `ea` = `upd_val` = `base` − 2^`size`.
- R9: Mode code 7 (circular, up) gives `ea` = `base`. Let off = `base` − `buf_start` and step = 2^`size`, with off < `buf_len` and step ≤ `buf_len`. Then `upd_val` = `buf_start` + (off + step), less `buf_len` when that sum is at least `buf_len`.
- R10: Mode code 8 (circular, down) gives `ea` = `base`. With off and step as in R9, `upd_val` = `buf_start` + off − step, plus `buf_len` when off < step.
- R11: Mode code 9 (bit-reversed) requires `buf_len` = 2^k and gives `ea` = `base`. With off = `base` − `buf_start` (off < `buf_len`), `upd_val` = `buf_start` + rev_k(rev_k(off) + 1 mod 2^k), where rev_k reverses the low k bits. For k = 0 the new offset is 0.
- R12: `upd_en` is high only one cycle after an accepted request with mode code 5, 6, 7, 8 or 9. It is low after every other code and after idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Request present this cycle |
| mode | input | 4 | Addressing-mode code |
| base | input | AW | Base register value |
| index | input | AW | Index register value |
| disp | input | 16 | Instruction constant (displacement or absolute address) |
| scale | input | 2 | Index scale code |
| size | input | 2 | Access-size code (log2 bytes) |
| buf_start | input | AW | Circular / bit-reversed buffer start |
| buf_len | input | AW | Buffer length in address units |
| out_vld | output | 1 | Result valid |
| ea | output | AW | Effective address |
| upd_en | output | 1 | Base write-back required |
| upd_val | output | AW | New base value |

## Verification
The general modes are swept over every scale and size code. The bases sit near zero and near the top of the address space, so carries and wrap-around are exercised. The displacements include zero, +1, the largest positive value and negative values, which tells sign extension apart from zero extension, and the absolute mode apart from the displacement mode. The circular modes are tried at every in-buffer offset of buffer lengths that are odd, even and powers of two, with every legal step size, so both wrap points and the no-wrap path are each hit. The bit-reversed mode is swept over every offset of buffers of 1 to 16 entries. Each step is compared against the arithmetic reversal of the next index, which separates a correct reversal width from an off-by-one width.

// File: rtl/agu_pkg.sv
package agu_pkg;

    localparam int DISP_W = 16;

    typedef enum logic [3:0] {
        AM_REG_IND  = 4'd0,
        AM_DISP     = 4'd1,
        AM_INDEXED  = 4'd2,
        AM_ABS      = 4'd3,
        AM_SCALED   = 4'd4,
        AM_POST_INC = 4'd5,
        AM_PRE_DEC  = 4'd6,
        AM_CIRC_UP  = 4'd7,
        AM_CIRC_DN  = 4'd8,
        AM_BITREV   = 4'd9
    } agu_mode_e;

    function automatic logic mode_updates(input logic [3:0] m);
        return (m >= 4'(AM_POST_INC)) && (m <= 4'(AM_BITREV));
    endfunction

endpackage

// File: rtl/agu_linear.sv
module agu_linear #(
    parameter int AW = 32,
    parameter int DW = agu_pkg::DISP_W
) (
    input  logic [3:0]    mode,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] index,
    input  logic [DW-1:0] disp,
    input  logic [1:0]    scale,
    input  logic [1:0]    size,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] upd
);
    import agu_pkg::*;

    logic [AW-1:0] disp_sx;
    logic [AW-1:0] disp_zx;
    logic [AW-1:0] step;
    logic [AW-1:0] idx_scaled;

    assign disp_sx    = {{(AW-DW){disp[DW-1]}}, disp};
    assign disp_zx    = {{(AW-DW){1'b0}}, disp};
    assign step       = AW'(1) << size;
    assign idx_scaled = index << scale;

    always_comb begin
        ea  = base;
        upd = base;
        case (mode)
            4'(AM_DISP):     ea = base + disp_sx;
            4'(AM_INDEXED):  ea = base + index;
            4'(AM_ABS):      ea = disp_zx;
            4'(AM_SCALED):   ea = base + disp_sx + idx_scaled;
            4'(AM_POST_INC): upd = base + step;
            4'(AM_PRE_DEC): begin
                ea  = base - step;
                upd = base - step;
            end
            default: ea = base;
        endcase
    end
endmodule

// File: rtl/agu_circ.sv
module agu_circ #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] start,
    input  logic [AW-1:0] len,
    input  logic [1:0]    size,
    input  logic          down,
    output logic [AW-1:0] upd
);
    logic [AW-1:0] off;
    logic [AW-1:0] step;
    logic [AW-1:0] fwd;
    logic [AW-1:0] new_off;

    assign off  = base - start;
    assign step = AW'(1) << size;
    assign fwd  = off + step;

    always_comb begin
        if (down) begin
            if (off < step) new_off = off + len - step;
            else            new_off = off - step;
        end else begin
            if (fwd >= len) new_off = fwd - len;
            else            new_off = fwd;
        end
    end

    assign upd = start + new_off;
endmodule

// File: rtl/agu_bitrev.sv
module agu_bitrev #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] start,
    input  logic [AW-1:0] len,
    output logic [AW-1:0] upd
);
    localparam int KW = $clog2(AW + 1);

    logic [AW-1:0] off;
    logic [AW-1:0] off_rev;
    logic [AW-1:0] cnt;
    logic [AW-1:0] cnt_inc;
    logic [AW-1:0] inc_rev;
    logic [AW-1:0] mask;
    logic [KW-1:0] k;
    logic [KW-1:0] shamt;

    assign off  = base - start;
    assign mask = len - AW'(1);

    always_comb begin
        k = '0;
        for (int i = 0; i < AW; i++) begin
            if (len[i]) k = KW'(i);
        end
    end

    assign shamt = KW'(AW) - k;

    for (genvar g = 0; g < AW; g++) begin : g_rev
        assign off_rev[g] = off[AW-1-g];
        assign inc_rev[g] = cnt_inc[AW-1-g];
    end

    assign cnt     = off_rev >> shamt;
    assign cnt_inc = (cnt + AW'(1)) & mask;
    assign upd     = start + (inc_rev >> shamt);
endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit #(
    parameter int AW = 32,
    parameter int DW = agu_pkg::DISP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [3:0]    mode,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] index,
    input  logic [DW-1:0] disp,
    input  logic [1:0]    scale,
    input  logic [1:0]    size,
    input  logic [AW-1:0] buf_start,
    input  logic [AW-1:0] buf_len,
    output logic          out_vld,
    output logic [AW-1:0] ea,
    output logic          upd_en,
    output logic [AW-1:0] upd_val
);
    import agu_pkg::*;

    typedef struct packed {
        logic          vld;
        logic [AW-1:0] ea;
        logic          upd_en;
        logic [AW-1:0] upd;
    } agu_out_t;

    agu_out_t res_d, res_q;

    logic [AW-1:0] lin_ea, lin_upd, circ_upd, brv_upd;

    agu_linear #(.AW(AW), .DW(DW)) u_linear (
        .mode  (mode),
        .base  (base),
        .index (index),
        .disp  (disp),
        .scale (scale),
        .size  (size),
        .ea    (lin_ea),
        .upd   (lin_upd)
    );

    agu_circ #(.AW(AW)) u_circ (
        .base  (base),
        .start (buf_start),
        .len   (buf_len),
        .size  (size),
        .down  (mode == 4'(AM_CIRC_DN)),
        .upd   (circ_upd)
    );

    agu_bitrev #(.AW(AW)) u_bitrev (
        .base  (base),
        .start (buf_start),
        .len   (buf_len),
        .upd   (brv_upd)
    );

    always_comb begin
        res_d        = res_q;
        res_d.vld    = in_vld;
        res_d.upd_en = 1'b0;
        if (in_vld) begin
            res_d.upd_en = mode_updates(mode);
            case (mode)
                4'(AM_CIRC_UP), 4'(AM_CIRC_DN): begin
                    res_d.ea  = base;
                    res_d.upd = circ_upd;
                end
                4'(AM_BITREV): begin
                    res_d.ea  = base;
                    res_d.upd = brv_upd;
                end
                default: begin
                    res_d.ea  = lin_ea;
                    res_d.upd = lin_upd;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_vld = res_q.vld;
    assign ea      = res_q.ea;
    assign upd_en  = res_q.upd_en;
    assign upd_val = res_q.upd;
endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
    parameter int AW = 32,
    parameter int DW = agu_pkg::DISP_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_vld,
    input logic [3:0]    mode,
    input logic [AW-1:0] base,
    input logic [DW-1:0] disp,
    input logic [1:0]    size,
    input logic [AW-1:0] buf_start,
    input logic [AW-1:0] buf_len,
    input logic          out_vld,
    input logic [AW-1:0] ea,
    input logic          upd_en,
    input logic [AW-1:0] upd_val
);
    logic circ_ok;
    assign circ_ok = in_vld && (mode == 4'd7 || mode == 4'd8)
                     && ((base - buf_start) < buf_len)
                     && ((AW'(1) << size) <= buf_len);

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld == $past(in_vld)); // R2
    AST_IDLE_NO_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> !upd_en); // R12
    AST_PLAIN_NO_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && (mode < 4'd5 || mode > 4'd9)) |=> !upd_en); // R12
    AST_ABS_ZX: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && mode == 4'd3) |=> ea == AW'($past(disp))); // R3
    AST_POST_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && mode == 4'd5) |=> (ea == $past(base)) &&
        (upd_val == $past(base) + (AW'(1) << $past(size))) && upd_en); // R7
    AST_PRE_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && mode == 4'd6) |=> (ea == upd_val) && upd_en); // R8
    AST_CIRC_IN_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        circ_ok |=> (upd_val - $past(buf_start)) < $past(buf_len)); // R9 R10
endmodule

bind addr_gen_unit agu_chk #(.AW(AW), .DW(DW)) u_agu_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vld    (in_vld),
    .mode      (mode),
    .base      (base),
    .disp      (disp),
    .size      (size),
    .buf_start (buf_start),
    .buf_len   (buf_len),
    .out_vld   (out_vld),
    .ea        (ea),
    .upd_en    (upd_en),
    .upd_val   (upd_val)
);

// File: tb/addr_gen_unit_bench.sv
module addr_gen_unit_bench;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_vld = 1'b0;
    logic [3:0]    mode = '0;
    logic [AW-1:0] base = '0, index = '0, buf_start = '0, buf_len = '0;
    logic [15:0]   disp = '0;
    logic [1:0]    scale = '0, size = '0;
    logic          out_vld, upd_en;
    logic [AW-1:0] ea, upd_val;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    addr_gen_unit #(.AW(AW)) u_addr_gen_unit (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .mode(mode), .base(base),
        .index(index), .disp(disp), .scale(scale), .size(size),
        .buf_start(buf_start), .buf_len(buf_len), .out_vld(out_vld),
        .ea(ea), .upd_en(upd_en), .upd_val(upd_val)
    );

    function automatic logic [31:0] rev_low(input logic [31:0] v, input int k);
        logic [31:0] r = '0;
        for (int i = 0; i < k; i++) r[i] = v[k-1-i];
        return r;
    endfunction

    task automatic cmp(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s mode=%0d base=%h act=%h exp=%h", req, mode, base, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] m, input logic [31:0] b, input logic [31:0] ix,
                         input logic [15:0] d, input logic [1:0] sc, input logic [1:0] sz,
                         input logic [31:0] st, input logic [31:0] ln);
        logic [31:0] dsx, stp, off, e_ea, e_upd, s;
        logic        e_en;
        int          k;
        @(negedge clk);
        mode = m; base = b; index = ix; disp = d; scale = sc; size = sz;
        buf_start = st; buf_len = ln; in_vld = 1'b1;
        dsx = {{16{d[15]}}, d};
        stp = 32'd1 << sz;
        off = b - st;
        e_ea = b; e_upd = b; e_en = 1'b0;
        case (m)
            4'd1: e_ea = b + dsx;
            4'd2: e_ea = b + ix;
            4'd3: e_ea = {16'd0, d};
            4'd4: e_ea = b + dsx + ix * (32'd1 << sc);
            4'd5: begin e_upd = b + stp; e_en = 1'b1; end
            4'd6: begin e_ea = b - stp; e_upd = b - stp; e_en = 1'b1; end
            4'd7: begin
                s = off + stp;
                e_upd = st + ((s >= ln) ? s - ln : s); e_en = 1'b1;
            end
            4'd8: begin
                e_upd = st + ((off < stp) ? off + ln - stp : off - stp); e_en = 1'b1;
            end
            4'd9: begin
                k = 0;
                for (int i = 0; i < 32; i++) if (ln[i]) k = i;
                e_upd = st + rev_low((rev_low(off, k) + 1) % ln, k);
                e_en = 1'b1;
            end
            default: ;
        endcase
        @(negedge clk);
        in_vld = 1'b0;
        cmp("R2 out_vld", {31'd0, out_vld}, 32'd1);
        case (m)
            4'd0, 4'd10, 4'd11, 4'd12, 4'd13, 4'd14, 4'd15, 4'd3: cmp("R3 ea", ea, e_ea);
            4'd1: cmp("R4 ea", ea, e_ea);
            4'd2: cmp("R5 ea", ea, e_ea);
            4'd4: cmp("R6 ea", ea, e_ea);
            4'd5: begin cmp("R7 ea", ea, e_ea); cmp("R7 upd", upd_val, e_upd); end
            4'd6: begin cmp("R8 ea", ea, e_ea); cmp("R8 upd", upd_val, e_upd); end
            4'd7: begin cmp("R9 ea", ea, e_ea); cmp("R9 upd", upd_val, e_upd); end
            4'd8: begin cmp("R10 ea", ea, e_ea); cmp("R10 upd", upd_val, e_upd); end
            default: begin cmp("R11 ea", ea, e_ea); cmp("R11 upd", upd_val, e_upd); end
        endcase
        cmp("R12 upd_en", {31'd0, upd_en}, {31'd0, e_en});
    endtask

    task automatic idle_check;
        @(negedge clk);
        in_vld = 1'b0;
        @(negedge clk);
        cmp("R2 idle out_vld", {31'd0, out_vld}, 32'd0);
        cmp("R12 idle upd_en", {31'd0, upd_en}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] bases [4];
        logic [15:0] disps [5];
        logic [31:0] idxs  [3];
        int          lens  [6];
        bases = '{32'h0, 32'h0000_1000, 32'hFFFF_FFF8, 32'h7FFF_FFFE};
        disps = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFE};
        idxs  = '{32'h0, 32'h3, 32'h100};
        lens  = '{1, 2, 3, 5, 8, 16};

        repeat (3) @(negedge clk);
        cmp("R1 reset out_vld", {31'd0, out_vld}, 32'd0);
        cmp("R1 reset upd_en", {31'd0, upd_en}, 32'd0);
        cmp("R1 reset ea", ea, 32'd0);
        cmp("R1 reset upd_val", upd_val, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp("R1 after reset out_vld", {31'd0, out_vld}, 32'd0);

        for (int m = 0; m < 16; m++) begin
            if (m >= 7 && m <= 9) continue;
            foreach (bases[b])
                foreach (disps[d])
                    foreach (idxs[x])
                        for (int sc = 0; sc < 4; sc++)
                            for (int sz = 0; sz < 4; sz++)
                                apply(4'(m), bases[b], idxs[x], disps[d], 2'(sc), 2'(sz),
                                      32'h0, 32'h10);
        end
        idle_check();

        foreach (lens[l])
            for (int sz = 0; sz < 4; sz++) begin
                if ((1 << sz) > lens[l]) continue;
                for (int o = 0; o < lens[l]; o++) begin
                    apply(4'd7, 32'h2000 + 32'(o), 32'h0, 16'h0, 2'd0, 2'(sz),
                          32'h2000, 32'(lens[l]));
                    apply(4'd8, 32'h2000 + 32'(o), 32'h0, 16'h0, 2'd0, 2'(sz),
                          32'h2000, 32'(lens[l]));
                end
            end
        idle_check();

        for (int k = 0; k <= 4; k++)
            for (int o = 0; o < (1 << k); o++)
                apply(4'd9, 32'h8000_0040 + 32'(o), 32'h0, 16'h0, 2'd0, 2'd0,
                      32'h8000_0040, 32'(1 << k));
        idle_check();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule